// File: doc/BRIEF.md
# Maskable Interrupt Arbiter with Priority Elevation

This block gathers the fifteen maskable interrupt sources of a small microcontroller and tells the CPU which one to serve next. Fourteen sources have an event flag, held in a register bank, that is set by a one-cycle pulse from their peripheral. The fifteenth is the external interrupt pin. It is active low and level sensitive, and it has no stored flag. Every source also has a local enable bit. A source counts as recognized when its flag (or the pin level) and its enable bit are both 1.

Among the recognized sources the block picks one. The default order is fixed. A 4-bit select register can promote any single source above all the others, and the rest keep their relative order. The block raises a registered request with the winner's vector index while the CPU's global interrupt-disable bit is clear. When the CPU acknowledges, the request is held off until the CPU has shown its disable bit set. This closes the gap before the disable bit takes effect.

Software reaches the flags, the enables and the select code through a small synchronous register port with a combinational read.

Top module: `pirq_ctrl`

## Requirements
- R1: A pulse on `evt_pulse[k]` sets the flag of source k+1 at the next clock edge, whether or not that source is enabled. The flag register is address 0, and source s reads at bit s.
- R2: Writing address 0 clears every flag whose data bit is 1. A data bit of 0 leaves its flag unchanged. No write can set a flag.
- R3: If an event pulse and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R4: The enable register (address 1, bit s for source s) is plain read/write. A source is recognized only while its flag and its enable bit are both 1. Enabling a source whose flag is already set raises the request on the next clock edge.
- R5: `int_req` is 1 only in a cycle that follows an edge at which `cpu_i_bit` was 0 and some source was recognized.
- R6: With no source promoted, the winner is the recognized source with the lowest index. The index order is: 0 pin, 1 periodic timer, 2–4 capture 1–3, 5–8 compare 1–4, 9 capture 4/compare 5, 10 timer overflow, 11 pulse-count overflow, 12 pulse edge, 13 SPI, 14 SCI. `int_vec` carries the winner's index.
- R7: The select register (address 2, bits 3:0) promotes source s when it holds (s+6) mod 16. For example, 6 selects the pin, 7 the periodic timer and 4 the SCI. If the promoted source is recognized it wins. Code 5 promotes nothing.
- R8: The external pin `irq_n` is active low. It passes through a two-stage synchronizer and has no stored flag. Its synchronized level reads at bit 0 of address 0, and it requests with vector 0 while enabled and low.
- R9: After a cycle with `int_ack` high, `int_req` stays 0 until the block has sampled `cpu_i_bit` as 1 at least once.
- R10: Reset clears all flags, enables and the request, and loads the select register with 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 14 | One-cycle event pulses for sources 1..14 (bit k is source k+1) |
| irq_n | input | 1 | External interrupt pin, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 flags, 1 enables, 2 select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| cpu_i_bit | input | 1 | CPU global maskable-interrupt disable bit |
| int_ack | input | 1 | CPU acknowledge of the current request |
| int_req | output | 1 | Registered interrupt request |
| int_vec | output | 4 | Registered index of the winning source |

## Verification
If a flag is lost or appears spuriously, the fault shows on `reg_rdata` in the same cycle it is read, and on `int_req`/`int_vec` one edge after the flag changes. A wrong elevation decode or priority scan gives a wrong `int_vec` one edge after the recognized set settles. The bench therefore sweeps every select code against many recognized patterns. A stale hold-off state after an acknowledge shows as a request that is missing or arrives early around toggles of `cpu_i_bit`. A pin-synchronizer fault moves the request edge away from the third clock edge after the pin changes.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NSRC     = 15;
  localparam int SELW     = 4;
  localparam int DW       = 16;
  localparam int VECW     = 4;
  localparam int NFLAG    = NSRC - 1;
  localparam int CODE_OFS = 6;
  localparam logic [SELW-1:0] SEL_RESET = SELW'(CODE_OFS);

  typedef enum logic [1:0] {
    RA_FLAG = 2'd0,
    RA_MASK = 2'd1,
    RA_SEL  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  function automatic logic [SELW-1:0] pos_to_code(input int unsigned pos);
    return SELW'((pos + CODE_OFS) % (1 << SELW));
  endfunction
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = din;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NFLAG-1:0] evt,
  input  logic             pin_active,
  output logic [NSRC-1:0]  flag_vec,
  output logic [NSRC-1:0]  mask_vec,
  output logic [SELW-1:0]  sel_code,
  output logic [DW-1:0]    rdata
);
  logic [NFLAG-1:0] flag_q, flag_d, clr_bits;
  logic [NSRC-1:0]  mask_q, mask_d;
  logic [SELW-1:0]  sel_q, sel_d;
  logic             mask_en, sel_en;

  always_comb begin
    clr_bits = '0;
    if (wr_en && reg_addr_e'(addr) == RA_FLAG) clr_bits = wdata[NSRC-1:1];
    flag_d  = (flag_q & ~clr_bits) | evt;
    mask_en = wr_en && reg_addr_e'(addr) == RA_MASK;
    sel_en  = wr_en && reg_addr_e'(addr) == RA_SEL;
    mask_d  = wdata[NSRC-1:0];
    sel_d   = wdata[SELW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      sel_q  <= SEL_RESET;
    end else begin
      flag_q <= flag_d;
      if (mask_en) mask_q <= mask_d;
      if (sel_en)  sel_q  <= sel_d;
    end
  end

  assign flag_vec = {flag_q, pin_active};
  assign mask_vec = mask_q;
  assign sel_code = sel_q;

  always_comb begin
    rdata = '0;
    unique case (reg_addr_e'(addr))
      RA_FLAG: rdata[NSRC-1:0] = flag_vec;
      RA_MASK: rdata[NSRC-1:0] = mask_q;
      RA_SEL:  rdata[SELW-1:0] = sel_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pirq_arb.sv
module pirq_arb
  import pirq_pkg::*;
(
  input  logic [NSRC-1:0] recog,
  input  logic [SELW-1:0] sel_code,
  output logic            any,
  output logic [VECW-1:0] win_idx
);
  logic            elev_hit;
  logic [VECW-1:0] elev_idx, dflt_idx;

  always_comb begin
    elev_hit = 1'b0;
    elev_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_code == pos_to_code(i)) begin
        elev_hit = recog[i];
        elev_idx = VECW'(i);
      end
    end
    dflt_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (recog[i]) dflt_idx = VECW'(i);
    end
    any     = |recog;
    win_idx = elev_hit ? elev_idx : dflt_idx;
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_pulse,
  input  logic             irq_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             cpu_i_bit,
  input  logic             int_ack,
  output logic             int_req,
  output logic [VECW-1:0]  int_vec
);
  logic            pin_n_sync;
  logic [NSRC-1:0] flag_vec, mask_vec, recog;
  logic [SELW-1:0] sel_code;
  logic            any;
  logic [VECW-1:0] win_idx;
  logic            hold_q, hold_d;
  logic            req_q, req_d;
  logic [VECW-1:0] vec_q;

  pirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_n), .dout(pin_n_sync)
  );

  pirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .evt(evt_pulse), .pin_active(~pin_n_sync),
    .flag_vec(flag_vec), .mask_vec(mask_vec), .sel_code(sel_code),
    .rdata(reg_rdata)
  );

  assign recog = flag_vec & mask_vec;

  pirq_arb u_arb (
    .recog(recog), .sel_code(sel_code), .any(any), .win_idx(win_idx)
  );

  always_comb begin
    hold_d = hold_q;
    if (cpu_i_bit)    hold_d = 1'b0;
    else if (int_ack) hold_d = 1'b1;
    req_d = any && !cpu_i_bit && !hold_q && !int_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      req_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      hold_q <= hold_d;
      req_q  <= req_d;
      vec_q  <= win_idx;
    end
  end

  assign int_req = req_q;
  assign int_vec = vec_q;
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk
  import pirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] evt_pulse,
  input logic             cpu_i_bit,
  input logic             int_ack,
  input logic             int_req,
  input logic [VECW-1:0]  int_vec,
  input logic [NSRC-1:0]  flag_vec
);
  logic [NFLAG-1:0] flags;
  assign flags = flag_vec[NSRC-1:1];

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((flags & $past(evt_pulse)) == $past(evt_pulse))); // R1

  AST_NO_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(evt_pulse)) == '0)); // R2

  AST_REQ_NEEDS_I_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !$past(cpu_i_bit)); // R5

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int_vec < VECW'(NSRC))); // R6

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !int_req); // R9
endmodule

bind pirq_ctrl pirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cpu_i_bit(cpu_i_bit),
  .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec), .flag_vec(flag_vec)
);

// File: tb/pirq_ctrl_test.sv
`timescale 1ns/1ps
module pirq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] evt_pulse;
  logic        irq_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        cpu_i_bit;
  logic        int_ack;
  logic        int_req;
  logic [3:0]  int_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .irq_n(irq_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_i_bit(cpu_i_bit), .int_ack(int_ack),
    .int_req(int_req), .int_vec(int_vec)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [13:0] e);
    evt_pulse = e;
    tick(1);
    evt_pulse = '0;
  endtask

  function automatic int model_win(input logic [14:0] rec, input int code);
    int elev = (code + 10) % 16;
    if (elev < 15 && rec[elev]) return elev;
    for (int i = 0; i < 15; i++) if (rec[i]) return i;
    return -1;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; evt_pulse = '0; irq_n = 1'b1; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; cpu_i_bit = 1'b0; int_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R10 reset state
    check(int_req == 1'b0, "R10 req", int_req, 0);
    rd(2'd0, d); check(d == 16'h0, "R10 flags", d, 0);
    rd(2'd1, d); check(d == 16'h0, "R10 masks", d, 0);
    rd(2'd2, d); check(d == 16'h6, "R10 select", d, 6);

    // R1 flag set while masked, no request (R4)
    pulse(14'h0004);            // source 3
    tick(2);
    rd(2'd0, d); check(d == 16'h0008, "R1 flag masked", d, 16'h0008);
    check(int_req == 1'b0, "R4 masked no req", int_req, 0);

    // R4 enable with flag already set -> request next edge
    wr(2'd1, 16'h0008);
    rd(2'd1, d); check(d == 16'h0008, "R4 mask readback", d, 8);
    tick(1);
    check(int_req == 1'b1 && int_vec == 4'd3, "R4 immediate recog", {int_req, int_vec}, 5'h13);

    // R2 write 0 keeps, write 1 clears, cannot set
    wr(2'd0, 16'h0000);
    rd(2'd0, d); check(d == 16'h0008, "R2 write0 keeps", d, 8);
    wr(2'd0, 16'h7FF8);
    tick(1);
    rd(2'd0, d); check(d == 16'h0000, "R2 w1c clears no set", d, 0);
    check(int_req == 1'b0, "R2 req drops", int_req, 0);

    // R3 set wins over clear
    wr(2'd1, 16'h0020);
    evt_pulse = 14'h0010;       // source 5
    wr(2'd0, 16'h0020);
    evt_pulse = '0;
    rd(2'd0, d); check(d == 16'h0020, "R3 set wins", d, 16'h0020);

    // R5 I bit blocks
    cpu_i_bit = 1'b1;
    tick(2);
    check(int_req == 1'b0, "R5 blocked by I", int_req, 0);
    cpu_i_bit = 1'b0;
    tick(1);
    check(int_req == 1'b1 && int_vec == 4'd5, "R5 req after I clear", {int_req, int_vec}, 5'h15);

    // R9 ack hold-off
    int_ack = 1'b1; tick(1); int_ack = 1'b0;
    check(int_req == 1'b0, "R9 drop on ack", int_req, 0);
    tick(4);
    check(int_req == 1'b0, "R9 held until I seen", int_req, 0);
    cpu_i_bit = 1'b1; tick(1); cpu_i_bit = 1'b0;
    check(int_req == 1'b0, "R9 still I set", int_req, 0);
    tick(1);
    check(int_req == 1'b1 && int_vec == 4'd5, "R9 re-request", {int_req, int_vec}, 5'h15);
    wr(2'd0, 16'h7FFE);
    wr(2'd1, 16'h0000);

    // R8 pin synchronizer timing and level behaviour
    wr(2'd1, 16'h0001);
    irq_n = 1'b0;
    tick(2);
    check(int_req == 1'b0, "R8 sync latency", int_req, 0);
    tick(1);
    check(int_req == 1'b1 && int_vec == 4'd0, "R8 pin request", {int_req, int_vec}, 5'h10);
    rd(2'd0, d); check(d == 16'h0001, "R8 pin level read", d, 1);
    irq_n = 1'b1;
    tick(3);
    check(int_req == 1'b0, "R8 no stored flag", int_req, 0);
    rd(2'd0, d); check(d == 16'h0000, "R8 level gone", d, 0);

    // R6/R7 sweep over all select codes and many patterns
    wr(2'd1, 16'h7FFF);
    for (int code = 0; code < 16; code++) begin
      wr(2'd2, 16'(code));
      rd(2'd2, d); check(d == 16'(code), "R7 select readback", d, code);
      for (int k = 0; k < 12; k++) begin
        logic [14:0] p;
        int w;
        p = 15'((k * 9173 + 1237 + code * 311) ^ (k << 5));
        if (k == 0) p = 15'h0;
        if (k == 1) p = 15'h7FFF;
        irq_n = ~p[0];
        pulse(p[14:1]);
        tick(3);
        w = model_win(p, code);
        if (w < 0)
          check(int_req == 1'b0, "R6 none recognized", int_req, 0);
        else
          check(int_req == 1'b1 && int_vec == 4'(w),
                (code == 5 || w == (code + 10) % 16) ? "R7 elevated/fallback" : "R6 default order",
                int_vec, w);
        irq_n = 1'b1;
        wr(2'd0, 16'h7FFE);
        tick(3);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule